// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Control Register

This block is a single 64-bit control and status register shared by up to four processors. It keeps one interval-timer flag and one interprocessor-interrupt flag for each processor. It also holds two four-bit arbitration fields and a four-bit plain read/write field. Each processor has one interprocessor-interrupt line and one timer-interrupt line, and each line is driven straight from its stored flag.

A write is one cycle with `wr_en` high, and all 64 data bits are applied at once. Each field has its own write rule:
- Some bits are cleared by writing a one.
- Some bits are set by writing a one.
- One field can only be set while it is empty.
- One bit, when written as one, wipes both arbitration fields.
- A request nibble sets the interprocessor flags but is never stored itself.

A separate tick counter sends per-processor `timer_set` pulses. These pulses are the only way to raise a timer flag.

Reads are combinational. `rd_data` returns the stored image with the reading processor's two-bit index merged into bits 1:0. The register has no streaming data path, so every pin is a plain level or a one-cycle strobe, with no valid/ready handshake.

Top module: `ipi_misc_reg`

## Requirements
- R1: Reset clears every stored bit. While the register is cleared, `rd_data` equals the zero-extended `rd_cpu`, and all interrupt outputs are low.
- R2: On a write, a 1 in data bits 4–11 clears the matching stored bit. A 0 leaves that bit unchanged. A cycle with `wr_en` low changes nothing.
- R3: Write data bits 12–15 set stored bits 8–11 (bit 12+i sets bit 8+i). This set is applied after the clear of R2, so setting and clearing the same flag in one write leaves it set. Bits 12–15 always read as zero.
- R4: When write data bit 20 is 1, stored bits 16–23 are all cleared, and the set rules of R5 and R6 are skipped for that write.
- R5: When write data bit 20 is 0, write data bits 21–23 are ORed into stored bits 21–23 (write-one-to-set).
- R6: When write data bit 20 is 0, write data bits 16–19 are ORed into stored bits 16–19 only if those stored bits are all zero before the write. Otherwise they are left unchanged.
- R7: Stored bits 40–43 take write data bits 40–43 on every write.
- R8: `rd_data` equals the stored image ORed with `rd_cpu` in bits 1:0.
- R9: Stored bit 4+i is set by a `timer_set[i]` pulse and by nothing else. If the pulse and a write that clears the bit arrive in the same cycle, the pulse wins.
- R10: `ipi_irq[i]` equals stored bit 8+i, and `timer_irq[i]` equals stored bit 4+i, both valid from the cycle after the update.
- R11: Bits 2–3, 12–15, 24–39 and 44–63 read as zero whatever is written; bit 28 is included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 64 | Write data, applied field by field |
| rd_cpu | input | 2 | Index of the reading processor |
| timer_set | input | NUM_PROC | Per-processor timer-flag set pulses |
| rd_data | output | 64 | Stored image with the reader index in bits 1:0 |
| ipi_irq | output | NUM_PROC | Interprocessor interrupt per processor |
| timer_irq | output | NUM_PROC | Timer interrupt per processor |

## Verification
The assertions assume that `timer_set` pulses and `wr_en` are clean levels sampled at the rising edge, with no X values once reset is released. They also assume that `wr_en` and `timer_set` may coincide, so no ordering between the two is required.

The stimulus drives every input on the falling edge and holds it for exactly one rising edge. It then samples `rd_data` and the interrupt lines one time unit after that edge, so each check sees the state produced by one update. The stimulus deliberately collides a timer pulse with a clearing write. It also issues writes that combine a clear with a set, or a wipe with a set, so the order of the rules is checked.

// File: rtl/ipi_misc_pkg.sv
package ipi_misc_pkg;

  localparam int FLD_W     = 4;
  localparam int ITI_LO    = 4;
  localparam int IPI_LO    = 8;
  localparam int REQ_LO    = 12;
  localparam int ABW_LO    = 16;
  localparam int ABT_LO    = 20;
  localparam int WIPE_BIT  = 20;
  localparam int USER_LO   = 40;
  localparam int IDX_W     = 2;

  typedef struct packed {
    logic [FLD_W-1:0] user;
    logic [FLD_W-1:0] abt;
    logic [FLD_W-1:0] abw;
    logic [FLD_W-1:0] ipi;
    logic [FLD_W-1:0] iti;
  } misc_state_t;

endpackage

// File: rtl/ipi_misc_merge.sv
module ipi_misc_merge
  import ipi_misc_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int DATA_W   = 64
) (
  input  misc_state_t         cur,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [NUM_PROC-1:0] timer_set,
  output misc_state_t         nxt
);

  logic [FLD_W-1:0] clr_iti, clr_ipi, req, abw_in, abt_in, user_in;
  logic             wipe;

  assign clr_iti = wr_data[ITI_LO  +: FLD_W];
  assign clr_ipi = wr_data[IPI_LO  +: FLD_W];
  assign req     = wr_data[REQ_LO  +: FLD_W];
  assign abw_in  = wr_data[ABW_LO  +: FLD_W];
  assign abt_in  = wr_data[ABT_LO  +: FLD_W];
  assign user_in = wr_data[USER_LO +: FLD_W];
  assign wipe    = wr_data[WIPE_BIT];

  always_comb begin
    nxt = cur;
    if (wr_en) begin
      nxt.iti  = cur.iti & ~clr_iti;
      nxt.ipi  = (cur.ipi & ~clr_ipi) | req;
      nxt.user = user_in;
      if (wipe) begin
        nxt.abt = '0;
        nxt.abw = '0;
      end else begin
        nxt.abt = cur.abt | abt_in;
        if (cur.abw == '0) nxt.abw = abw_in;
      end
    end
    for (int i = 0; i < FLD_W; i++) begin
      if (i < NUM_PROC) begin
        if (timer_set[i]) nxt.iti[i] = 1'b1;
      end else begin
        nxt.iti[i] = 1'b0;
        nxt.ipi[i] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/ipi_misc_store.sv
module ipi_misc_store
  import ipi_misc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  misc_state_t d,
  output misc_state_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/ipi_misc_readback.sv
module ipi_misc_readback
  import ipi_misc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  misc_state_t       st,
  input  logic [IDX_W-1:0]  rd_cpu,
  output logic [DATA_W-1:0] rd_data
);

  always_comb begin
    rd_data = '0;
    rd_data[IDX_W-1:0]        = rd_cpu;
    rd_data[ITI_LO  +: FLD_W] = st.iti;
    rd_data[IPI_LO  +: FLD_W] = st.ipi;
    rd_data[ABW_LO  +: FLD_W] = st.abw;
    rd_data[ABT_LO  +: FLD_W] = st.abt;
    rd_data[USER_LO +: FLD_W] = st.user;
  end

endmodule

// File: rtl/ipi_misc_reg.sv
module ipi_misc_reg
  import ipi_misc_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int DATA_W   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [1:0]          rd_cpu,
  input  logic [NUM_PROC-1:0] timer_set,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_PROC-1:0] ipi_irq,
  output logic [NUM_PROC-1:0] timer_irq
);

  localparam logic [DATA_W-1:0] LIVE_MASK =
      (DATA_W'(1) << IDX_W) - 1
    | ({{(DATA_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << ITI_LO)
    | ({{(DATA_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << IPI_LO)
    | ({{(DATA_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << ABW_LO)
    | ({{(DATA_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << ABT_LO)
    | ({{(DATA_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << USER_LO);

  misc_state_t st_q, st_d;

  ipi_misc_merge #(.NUM_PROC(NUM_PROC), .DATA_W(DATA_W)) u_merge (
    .cur(st_q), .wr_en(wr_en), .wr_data(wr_data),
    .timer_set(timer_set), .nxt(st_d)
  );

  ipi_misc_store u_store (.clk(clk), .rst_n(rst_n), .d(st_d), .q(st_q));

  ipi_misc_readback #(.DATA_W(DATA_W)) u_rb (
    .st(st_q), .rd_cpu(rd_cpu), .rd_data(rd_data)
  );

  assign ipi_irq   = st_q.ipi[NUM_PROC-1:0];
  assign timer_irq = st_q.iti[NUM_PROC-1:0];

  // R4
  wipe_clears_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[WIPE_BIT]) |=> (rd_data[ABW_LO +: 2*FLD_W] == '0));

  // R6
  abw_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[ABW_LO +: FLD_W] != '0 && !(wr_en && wr_data[WIPE_BIT]))
      |=> $stable(rd_data[ABW_LO +: FLD_W]));

  // R7
  user_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[USER_LO +: FLD_W] == $past(wr_data[USER_LO +: FLD_W])));

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE_MASK) == '0);

  // R8
  index_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] == rd_cpu);

  generate
    for (genvar g = 0; g < NUM_PROC; g++) begin : g_proc_chk
      // R9
      iti_timer_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_irq[g]) |-> $past(timer_set[g]));
      // R9
      timer_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_set[g] |=> timer_irq[g]);
      // R3
      req_sets_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[REQ_LO + g]) |=> ipi_irq[g]);
    end
  endgenerate

endmodule

// File: tb/ipi_misc_reg_bench.sv
module ipi_misc_reg_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic        wr;
    logic [63:0] data;
    logic [3:0]  tmr;
    logic [1:0]  cpu;
    logic [63:0] exp;
  } vec_t;

  // Field positions: ITI 7:4, IPI 11:8, request 15:12, ABW 19:16,
  // wipe bit 20, ABT 23:20, user field 43:40, reader index 1:0.
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 64'h0,                   4'b0101, 2'd2, 64'h52},                // R9 timer set
    '{1'b1, 64'h000000000000F000,    4'b0000, 2'd0, 64'hF50},               // R3 request
    '{1'b1, 64'h0000000000000510,    4'b0000, 2'd1, 64'hA41},               // R2 clear
    '{1'b1, 64'h0000000000E00000,    4'b0000, 2'd0, 64'hE00A40},            // R5 ABT set
    '{1'b1, 64'h0000000000030000,    4'b0000, 2'd0, 64'hE30A40},            // R6 ABW empty
    '{1'b1, 64'h00000000000C0000,    4'b0000, 2'd0, 64'hE30A40},            // R6 ABW locked
    '{1'b1, 64'h0000000000100000,    4'b0000, 2'd0, 64'hA40},               // R4 wipe
    '{1'b1, 64'h0000000000E50000,    4'b0000, 2'd0, 64'hE50A40},            // R5 R6 refill
    '{1'b1, 64'h0000000000FF0000,    4'b0000, 2'd0, 64'hA40},               // R4 wipe beats set
    '{1'b1, 64'h00000A0000000000,    4'b0000, 2'd0, 64'h00000A0000000A40},  // R7
    '{1'b1, 64'h0000050000000000,    4'b0000, 2'd0, 64'h0000050000000A40},  // R7
    '{1'b1, 64'hFFFFF5FFFF00000F,    4'b0000, 2'd3, 64'h0000050000000A43},  // R11 R8
    '{1'b1, 64'h00000500000000C0,    4'b1000, 2'd0, 64'h0000050000000A80},  // R9 collision
    '{1'b1, 64'h0000050000002270,    4'b0000, 2'd0, 64'h0000050000000A80}   // R3 R9 no write-set
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_cpu = '0;
  logic [3:0]  timer_set = '0;
  logic [63:0] rd_data;
  logic [3:0]  ipi_irq, timer_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_misc_reg u_ipi_misc_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_cpu(rd_cpu), .timer_set(timer_set), .rd_data(rd_data),
    .ipi_irq(ipi_irq), .timer_irq(timer_irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [63:0] d, input logic [3:0] t, input logic [1:0] c);
    @(negedge clk);
    wr_en = w; wr_data = d; timer_set = t; rd_cpu = c;
    @(posedge clk);
    #1;
    wr_en = 1'b0; timer_set = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rd_cpu = 2'd1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset image", rd_data, 64'h1);
    check("R1 reset irqs", {56'h0, ipi_irq, timer_irq}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k].wr, VEC[k].data, VEC[k].tmr, VEC[k].cpu);
      check($sformatf("R8 vector %0d read", k), rd_data, VEC[k].exp);
      check($sformatf("R10 vector %0d irqs", k), {56'h0, ipi_irq, timer_irq},
            {56'h0, VEC[k].exp[11:8], VEC[k].exp[7:4]});
    end

    // R2: data with wr_en low changes nothing
    step(1'b0, 64'hFFFFFFFFFFFFFFFF, 4'b0000, 2'd0);
    check("R2 idle write ignored", rd_data, 64'h0000050000000A80);

    // R2: clear every flag in one write
    step(1'b1, 64'h0000000000000FF0, 4'b0000, 2'd2);
    check("R2 clear all flags", rd_data, 64'h2);
    check("R10 irqs low after clear", {56'h0, ipi_irq, timer_irq}, 64'h0);

    // R1: reset in the middle of operation
    step(1'b1, 64'h000000000063F000, 4'b1111, 2'd0);
    check("R1 pre-reset load", rd_data, 64'h630FF0);
    @(negedge clk);
    rst_n = 1'b0;
    rd_cpu = 2'd3;
    @(posedge clk);
    #1;
    check("R1 mid-run reset", rd_data, 64'h3);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule